// File: doc/BRIEF.md
# DMA Channel Interrupt and Handshake Control

This block holds the control and status state for one DMA channel. It has two jobs. The first is to decide when the channel interrupts the processor. The second is to tell the transfer engine which bus phase the external request, acknowledge and done handshake belongs to. The transfer engine sends one-cycle event pulses: breakpoint seen, normal completion, source read error, destination write error and configuration error. Each pulse sets a sticky status flag. Three cause terms each have their own enable: breakpoint, normal completion and error. The OR of the enabled cause terms drives an active-low, registered interrupt line.

Software uses a small register port. The port writes a control word, reads it back, reads the status flags and clears each flag by writing 1 to its bit. The external control option bit (`ext_opt`) changes meaning with the address mode. In single-address mode it sets the direction of data relative to the requesting device. In dual-address mode it sets which device raises requests. When requests are internal, the bit has no effect.

The interrupt logic is a two-state machine. The states are `IRQ_IDLE` (line high) and `IRQ_ASSERT` (line low). The transition `IDLE->ASSERT` fires when any enabled cause becomes true. The transition `ASSERT->IDLE` fires when every enabled cause is false. Both transitions are evaluated on the next-cycle values of the flags and the enables. As a result the line moves on the same clock edge as the flag or enable that caused the change.

Top module: `dma_chan_irq_ctl`

Register map:
- Offset 0 is the control word: bit0 `brk_ie`, bit1 `done_ie`, bit2 `err_ie`, bit3 `ext_opt`, bits5:4 `req_src`, bit6 `dual_mode`. Bit 7 reads 0.
- Offset 1 is status: bit0 breakpoint, bit1 done, bit2 source error, bit3 destination error, bit4 configuration error. Bits 7:5 read 0.
- Writing 1 to a status bit clears that flag.

## Requirements
- R1: A synchronous reset clears the control word and all status flags. After reset, `irq_n` is 1, all handshake outputs are 0 and both register offsets read 0.
- R2: A breakpoint pulse sets status bit0 only while `bus_owner` is 1. While `brk_ie` and status bit0 are both 1, `irq_n` is 0.
- R3: A completion pulse sets status bit1. While `done_ie` and status bit1 are both 1, `irq_n` is 0.
- R4: The source error pulse sets status bit2, the destination error pulse sets bit3 and the configuration error pulse sets bit4. While `err_ie` is 1 and any of these three bits is 1, `irq_n` is 0.
- R5: Writing 1 to a status bit at offset 1 clears only that bit. `irq_n` returns to 1 on the same clock edge at which the last enabled cause clears.
- R6: If an event pulse and a write-1-to-clear of the same flag fall in the same cycle, the flag stays set.
- R7: When `req_src` bit1 is 0 (values 00 and 01), `hs_rd_phase`, `hs_wr_phase`, `xfer_to_dev` and `src_requests` are all 0, whatever `ext_opt` and `dual_mode` hold.
- R8: In single-address mode (`dual_mode`=0) with `req_src`=1x:
  - `ext_opt`=1 gives `hs_rd_phase`=1 and `xfer_to_dev`=1.
  - `ext_opt`=0 gives `hs_wr_phase`=1 and `xfer_to_dev`=0.
  - `src_requests` stays 0 in both cases.
- R9: In dual-address mode (`dual_mode`=1) with `req_src`=1x:
  - `ext_opt`=1 gives `hs_rd_phase`=1 and `src_requests`=1.
  - `ext_opt`=0 gives `hs_wr_phase`=1 and `src_requests`=0.
  - `xfer_to_dev` stays 0 in both cases.
- R10: A flag whose cause enable is 0 does not pull `irq_n` low. The flag stays set, and writing its enable to 1 later pulls `irq_n` low on the edge of that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_owner | input | 1 | Channel currently owns the bus |
| ev_brk | input | 1 | Breakpoint recognised pulse |
| ev_done | input | 1 | Normal completion pulse |
| ev_src_err | input | 1 | Source read bus error pulse |
| ev_dst_err | input | 1 | Destination write bus error pulse |
| ev_cfg_err | input | 1 | Configuration error pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register offset: 0 control, 1 status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on `reg_addr`) |
| irq_n | output | 1 | Interrupt request, active low, registered |
| hs_rd_phase | output | 1 | Handshake applies to the read phase |
| hs_wr_phase | output | 1 | Handshake applies to the write phase |
| xfer_to_dev | output | 1 | Single-address: requester receives memory data |
| src_requests | output | 1 | Dual-address: source device raises requests |

## Verification
Flags, the control word and `irq_n` all change on the clock edge that captures the event pulse or register write. This holds because `irq_n` is computed from next-state values. Those results are due one edge after the stimulus is applied. The handshake outputs and `reg_rdata` are combinational from the control register and `reg_addr`. They are valid right after that same edge. The driver applies each stimulus across exactly one rising edge and queues the expected values just after that edge. The monitor compares them at the following falling edge, before the driver changes any input.

// File: rtl/dci_pkg.sv
package dci_pkg;
    localparam int NUM_FLAGS  = 5;
    localparam int CTRL_W     = 7;
    localparam int REG_W      = 8;

    localparam int FLG_BRK    = 0;
    localparam int FLG_DONE   = 1;
    localparam int FLG_SRCERR = 2;
    localparam int FLG_DSTERR = 3;
    localparam int FLG_CFGERR = 4;

    typedef struct packed {
        logic       dual_mode;
        logic [1:0] req_src;
        logic       ext_opt;
        logic       err_ie;
        logic       done_ie;
        logic       brk_ie;
    } ctrl_t;

    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_ASSERT = 1'b1
    } irq_state_e;
endpackage

// File: rtl/dci_status_flags.sv
module dci_status_flags #(
    parameter int NFLAG = dci_pkg::NUM_FLAGS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NFLAG-1:0] set_i,
    input  logic [NFLAG-1:0] clr_i,
    output logic [NFLAG-1:0] flags_q,
    output logic [NFLAG-1:0] flags_d
);
    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        // event has priority over the clear
        assign flags_d[g] = set_i[g] | (flags_q[g] & ~clr_i[g]);

        always_ff @(posedge clk) begin
            if (rst) flags_q[g] <= 1'b0;
            else     flags_q[g] <= flags_d[g];
        end

        // R6
        event_wins_chk: assert property (@(posedge clk) disable iff (rst)
            set_i[g] |=> flags_q[g]);

        // R5
        w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
            (clr_i[g] && !set_i[g]) |=> !flags_q[g]);
    end
endmodule

// File: rtl/dci_irq_fsm.sv
module dci_irq_fsm (
    input  logic clk,
    input  logic rst,
    input  logic cause_next,
    output logic irq_n
);
    import dci_pkg::*;

    irq_state_e state_q, state_d;

    always_comb begin
        unique case (state_q)
            IRQ_IDLE:   state_d = cause_next ? IRQ_ASSERT : IRQ_IDLE;
            IRQ_ASSERT: state_d = cause_next ? IRQ_ASSERT : IRQ_IDLE;
            default:    state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= IRQ_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        irq_n = (state_q != IRQ_ASSERT);
    end

    // R1
    irq_reset_chk: assert property (@(posedge clk)
        rst |=> irq_n);
endmodule

// File: rtl/dci_hs_decode.sv
module dci_hs_decode (
    input  dci_pkg::ctrl_t ctrl,
    output logic           hs_rd_phase,
    output logic           hs_wr_phase,
    output logic           xfer_to_dev,
    output logic           src_requests
);
    logic ext_req;

    always_comb begin
        ext_req      = ctrl.req_src[1];
        hs_rd_phase  = ext_req &  ctrl.ext_opt;
        hs_wr_phase  = ext_req & ~ctrl.ext_opt;
        xfer_to_dev  = ext_req & ~ctrl.dual_mode &  ctrl.ext_opt;
        src_requests = ext_req &  ctrl.dual_mode &  ctrl.ext_opt;
    end
endmodule

// File: rtl/dma_chan_irq_ctl.sv
module dma_chan_irq_ctl (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_owner,
    input  logic       ev_brk,
    input  logic       ev_done,
    input  logic       ev_src_err,
    input  logic       ev_dst_err,
    input  logic       ev_cfg_err,
    input  logic       reg_we,
    input  logic       reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq_n,
    output logic       hs_rd_phase,
    output logic       hs_wr_phase,
    output logic       xfer_to_dev,
    output logic       src_requests
);
    import dci_pkg::*;

    localparam int ERR_LO = FLG_SRCERR;
    localparam int ERR_HI = FLG_CFGERR;

    ctrl_t                ctrl_q, ctrl_d;
    logic [NUM_FLAGS-1:0] ev_vec, clr_vec, stat_q, stat_d;
    logic                 cause_next;

    always_comb begin
        ctrl_d = ctrl_q;
        if (reg_we && !reg_addr) ctrl_d = ctrl_t'(reg_wdata[CTRL_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else     ctrl_q <= ctrl_d;
    end

    always_comb begin
        ev_vec              = '0;
        ev_vec[FLG_BRK]     = ev_brk & bus_owner;
        ev_vec[FLG_DONE]    = ev_done;
        ev_vec[FLG_SRCERR]  = ev_src_err;
        ev_vec[FLG_DSTERR]  = ev_dst_err;
        ev_vec[FLG_CFGERR]  = ev_cfg_err;
        clr_vec = (reg_we && reg_addr) ? reg_wdata[NUM_FLAGS-1:0] : '0;
    end

    dci_status_flags #(.NFLAG(NUM_FLAGS)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_i   (ev_vec),
        .clr_i   (clr_vec),
        .flags_q (stat_q),
        .flags_d (stat_d)
    );

    always_comb begin
        cause_next = (ctrl_d.brk_ie  & stat_d[FLG_BRK])
                   | (ctrl_d.done_ie & stat_d[FLG_DONE])
                   | (ctrl_d.err_ie  & (|stat_d[ERR_HI:ERR_LO]));
    end

    dci_irq_fsm u_irq (
        .clk        (clk),
        .rst        (rst),
        .cause_next (cause_next),
        .irq_n      (irq_n)
    );

    dci_hs_decode u_hs (
        .ctrl         (ctrl_q),
        .hs_rd_phase  (hs_rd_phase),
        .hs_wr_phase  (hs_wr_phase),
        .xfer_to_dev  (xfer_to_dev),
        .src_requests (src_requests)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr) reg_rdata[NUM_FLAGS-1:0] = stat_q;
        else          reg_rdata[CTRL_W-1:0]    = ctrl_q;
    end

    // R2
    brk_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.brk_ie && stat_q[FLG_BRK]) |-> !irq_n);

    // R2
    brk_owner_chk: assert property (@(posedge clk) disable iff (rst)
        (!stat_q[FLG_BRK] && !bus_owner) |=> !stat_q[FLG_BRK] || $past(!rst && bus_owner));

    // R3
    done_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.done_ie && stat_q[FLG_DONE]) |-> !irq_n);

    // R4
    err_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.err_ie && (|stat_q[ERR_HI:ERR_LO])) |-> !irq_n);

    // R5
    irq_release_chk: assert property (@(posedge clk) disable iff (rst)
        !((ctrl_q.brk_ie && stat_q[FLG_BRK]) || (ctrl_q.done_ie && stat_q[FLG_DONE])
          || (ctrl_q.err_ie && (|stat_q[ERR_HI:ERR_LO]))) |-> irq_n);

    // R7
    internal_req_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.req_src[1] |-> !(hs_rd_phase || hs_wr_phase || xfer_to_dev || src_requests));

    // R8
    phase_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hs_rd_phase, hs_wr_phase}) && !(xfer_to_dev && src_requests));
endmodule

// File: tb/dma_chan_irq_ctl_tb.sv
module dma_chan_irq_ctl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_owner = 1'b0;
    logic       ev_brk = 1'b0, ev_done = 1'b0, ev_src_err = 1'b0;
    logic       ev_dst_err = 1'b0, ev_cfg_err = 1'b0;
    logic       reg_we = 1'b0, reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_n, hs_rd_phase, hs_wr_phase, xfer_to_dev, src_requests;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    typedef struct {
        string      tag;
        int         kind;
        logic [7:0] exp;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    dma_chan_irq_ctl dut_i (
        .clk(clk), .rst(rst), .bus_owner(bus_owner),
        .ev_brk(ev_brk), .ev_done(ev_done), .ev_src_err(ev_src_err),
        .ev_dst_err(ev_dst_err), .ev_cfg_err(ev_cfg_err),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_n(irq_n),
        .hs_rd_phase(hs_rd_phase), .hs_wr_phase(hs_wr_phase),
        .xfer_to_dev(xfer_to_dev), .src_requests(src_requests)
    );

    // monitor: compare queued expectations at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                exp_t it;
                logic [7:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    0:       act = {7'b0, irq_n};
                    1:       act = {4'b0, hs_rd_phase, hs_wr_phase, xfer_to_dev, src_requests};
                    default: act = reg_rdata;
                endcase
                n_chk++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic ex(string t, int k, logic [7:0] v);
        sb_q.push_back('{tag: t, kind: k, exp: v});
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
        reg_we = 1'b0;
        {ev_brk, ev_done, ev_src_err, ev_dst_err, ev_cfg_err} = '0;
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic wr(logic a, logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        cyc();
    endtask

    task automatic look(logic a);
        reg_addr = a;
        cyc();
    endtask

    // e = {cfg, dst, src, done, brk}; address parked on status
    task automatic pulse(logic [4:0] e, logic own);
        reg_addr = 1'b1;
        bus_owner = own;
        {ev_cfg_err, ev_dst_err, ev_src_err, ev_done, ev_brk} = e;
        cyc();
    endtask

    task automatic hs_case(string t, logic [7:0] c, logic [3:0] e);
        wr(1'b0, c);
        ex(t, 1, {4'b0, e});
        settle();
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        look(1'b0);
        ex("R1 irq", 0, 8'h01); ex("R1 hs", 1, 8'h00); ex("R1 ctrl", 2, 8'h00);
        settle();
        look(1'b1);
        ex("R1 status", 2, 8'h00);
        settle();

        // R2 breakpoint gated by bus ownership
        wr(1'b0, 8'h01); ex("R2 ctrl readback", 2, 8'h01); settle();
        pulse(5'b00001, 1'b0);
        ex("R2 no owner flag", 2, 8'h00); ex("R2 no owner irq", 0, 8'h01); settle();
        pulse(5'b00001, 1'b1);
        ex("R2 flag", 2, 8'h01); ex("R2 irq", 0, 8'h00); settle();
        wr(1'b1, 8'h01);
        ex("R5 brk cleared", 2, 8'h00); ex("R5 irq released", 0, 8'h01); settle();

        // R10 disabled cause, enabled later
        wr(1'b0, 8'h00); settle();
        pulse(5'b00001, 1'b1);
        ex("R10 flag kept", 2, 8'h01); ex("R10 irq idle", 0, 8'h01); settle();
        wr(1'b0, 8'h01);
        ex("R10 late enable irq", 0, 8'h00); settle();
        wr(1'b1, 8'h01); ex("R10 clear irq", 0, 8'h01); settle();

        // R3 normal completion
        wr(1'b0, 8'h02); settle();
        pulse(5'b00010, 1'b0);
        ex("R3 flag", 2, 8'h02); ex("R3 irq", 0, 8'h00); settle();
        wr(1'b1, 8'h02);
        ex("R3 cleared", 2, 8'h00); ex("R3 irq off", 0, 8'h01); settle();

        // R4 each error source
        wr(1'b0, 8'h04); settle();
        for (int i = 2; i < 5; i++) begin
            pulse(5'(1 << i), 1'b0);
            ex("R4 err flag", 2, 8'(1 << i)); ex("R4 err irq", 0, 8'h00); settle();
            wr(1'b1, 8'(1 << i));
            ex("R4 err clr", 2, 8'h00); ex("R4 err irq off", 0, 8'h01); settle();
        end

        // R5 partial clear keeps irq while a cause remains
        wr(1'b0, 8'h06); settle();
        pulse(5'b00110, 1'b0);
        ex("R5 two flags", 2, 8'h06); ex("R5 irq", 0, 8'h00); settle();
        wr(1'b1, 8'h02);
        ex("R5 partial", 2, 8'h04); ex("R5 irq held", 0, 8'h00); settle();
        wr(1'b1, 8'h04);
        ex("R5 all clear", 2, 8'h00); ex("R5 irq same edge", 0, 8'h01); settle();

        // R6 event beats clear in the same cycle
        wr(1'b0, 8'h02); settle();
        pulse(5'b00010, 1'b0); settle();
        reg_addr = 1'b1; reg_wdata = 8'h02; reg_we = 1'b1; ev_done = 1'b1;
        cyc();
        ex("R6 flag stays", 2, 8'h02); ex("R6 irq stays", 0, 8'h00); settle();
        wr(1'b1, 8'h02); ex("R6 final clear", 2, 8'h00); settle();

        // R7 internal requests ignore ext_opt; nibble {rd,wr,to_dev,src_req}
        hs_case("R7 internal single", 8'h08, 4'b0000);
        hs_case("R7 internal dual",   8'h48, 4'b0000);
        hs_case("R7 req 01",          8'h18, 4'b0000);
        // R8 single-address mode
        hs_case("R8 eco1 read",       8'h28, 4'b1010);
        hs_case("R8 eco0 write",      8'h20, 4'b0100);
        hs_case("R8 req11 eco1",      8'h38, 4'b1010);
        // R9 dual-address mode
        hs_case("R9 eco1 source",     8'h68, 4'b1001);
        hs_case("R9 eco0 dest",       8'h60, 4'b0100);
        hs_case("R9 req11 eco0",      8'h70, 4'b0100);

        settle();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule